// File: doc/BRIEF.md
# Synthetic-Trigger Deadtime Monitor

This block measures the live fraction of a trigger and readout chain. It emits synthetic trigger pulses of its own at a programmed spacing, either fixed or pseudo-random. The pulses are injected into the trigger logic alongside real detector signals. The block then counts how many of those pulses the readout path later reports as accepted. The ratio of accepted to emitted pulses gives the total live-time, covering both pile-up losses in the trigger logic and losses from busy modules. Software forms that ratio from the counters.

Four saturating counters are kept: pulses emitted, accepted pulses reported inside their acceptance window, accepted-pulse reports that arrive outside any window, and every physics trigger produced. A single latch strobe copies all four into shadow registers on the same edge, so a reader sees one coherent snapshot. The read port only reaches the shadows. A clear strobe zeroes the live counters.

Top module: `dtm_monitor`

## Requirements
- R1: After reset, `inject_out` is low and all four counters read zero through the read port.
- R2: With `cfg_random` low and `cfg_enable` high, `inject_out` is a one-cycle pulse that repeats every max(`cfg_period`,1) cycles, so a period of 0 behaves as 1.
- R3: While `cfg_enable` is low, no pulse is emitted.
- R4: With `cfg_random` high, the spacing between pulses varies and every spacing lies in [1, `cfg_period`+1].
- R5: The sent counter (read select 0) increments once for every emitted pulse.
- R6: A report (`acc_strobe` and `acc_synth` both high in one cycle) counts on the seen counter (select 1) when it falls in the cycle where `inject_out` is high or in the following `cfg_window`-1 cycles. With `cfg_window` = 0, no report is ever seen.
- R7: A report outside the window counts on the error counter (select 3). So does a second report after a seen one within the same window, because the first report closes the window.
- R8: `acc_strobe` without `acc_synth`, or `acc_synth` without `acc_strobe`, changes no counter and does not close the window.
- R9: The trigger counter (select 2) increments on every cycle in which `phys_trig` is high.
- R10: Every counter stops at 2^CNT_W-1 and never wraps.
- R11: `latch_cmd` copies all live counters, as they stood before that edge's increments, into the shadows. Shadows hold between latches. `rd_data` shows the shadow chosen by `rd_sel` (0 sent, 1 seen, 2 trigger, 3 error).
- R12: `clear_cmd` zeroes every live counter and takes priority over that edge's increments. A latch on the same edge captures the values from before the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Pulser enable |
| cfg_random | input | 1 | Pseudo-random spacing select |
| cfg_period | input | PERIOD_W | Fixed spacing, or random spacing mask |
| cfg_window | input | WIN_W | Acceptance window length in cycles |
| phys_trig | input | 1 | Physics trigger, one count per high cycle |
| acc_strobe | input | 1 | Readout accepted an event |
| acc_synth | input | 1 | Accepted event carried the synthetic pulse |
| latch_cmd | input | 1 | Copy live counters to shadows |
| clear_cmd | input | 1 | Zero live counters |
| rd_sel | input | 2 | Shadow select |
| rd_data | output | CNT_W | Selected shadow value |
| inject_out | output | 1 | Synthetic trigger pulse |

## Verification
The bench sweeps the report delay across both edges of the window, one pulse per delay. A window counted off by one would move a seen report to the error counter, or the other way round. It sends two reports against one pulse, and half-reports before a real one. A window that stays open would count the duplicate as seen, and a window closed by the strobe alone would lose the real report. It drives period 0, drives the trigger scaler past full scale, and issues a latch together with a clear while triggers arrive. A wrapping counter, or a clear that loses to an increment, shows up as a wrong read-back.

// File: rtl/dtm_pkg.sv
package dtm_pkg;

    localparam int NUM_CTR = 4;
    localparam int LFSR_W  = 32;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 32'hACE1_2468;
    localparam logic [LFSR_W-1:0] LFSR_TAPS = 32'h8020_0003;

    typedef enum logic [1:0] {
        CTR_SENT = 2'd0,
        CTR_SEEN = 2'd1,
        CTR_TRIG = 2'd2,
        CTR_ERR  = 2'd3
    } ctr_sel_e;

    // bit order matches ctr_sel_e: sent is bit 0
    typedef struct packed {
        logic err;
        logic trig;
        logic seen;
        logic sent;
    } ctr_inc_t;

    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return s[0] ? ((s >> 1) ^ LFSR_TAPS) : (s >> 1);
    endfunction

endpackage

// File: rtl/dtm_pulser.sv
module dtm_pulser
    import dtm_pkg::*;
#(
    parameter int PERIOD_W = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                enable,
    input  logic                random_mode,
    input  logic [PERIOD_W-1:0] period,
    output logic                fire,
    output logic                inject
);
    localparam int IVL_W = PERIOD_W + 1;

    logic [LFSR_W-1:0]   lfsr_q;
    logic [PERIOD_W-1:0] folded;
    logic [IVL_W-1:0]    cnt_q;
    logic [IVL_W-1:0]    rnd_ivl_q;
    logic [IVL_W-1:0]    fixed_ivl;
    logic [IVL_W-1:0]    ivl;

    // fold every state bit into the mask width
    always_comb begin
        folded = '0;
        for (int i = 0; i < LFSR_W; i++) begin
            folded[i % PERIOD_W] = folded[i % PERIOD_W] ^ lfsr_q[i];
        end
    end

    assign fixed_ivl = (period == '0) ? IVL_W'(1) : {1'b0, period};
    assign ivl       = random_mode ? rnd_ivl_q : fixed_ivl;
    assign fire      = enable && (cnt_q >= ivl - IVL_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            lfsr_q    <= LFSR_SEED;
            cnt_q     <= '0;
            rnd_ivl_q <= IVL_W'(1);
            inject    <= 1'b0;
        end else begin
            lfsr_q <= lfsr_step(lfsr_q);
            inject <= fire;
            if (!enable || fire) begin
                cnt_q     <= '0;
                rnd_ivl_q <= {1'b0, folded & period} + IVL_W'(1);
            end else begin
                cnt_q <= cnt_q + IVL_W'(1);
            end
        end
    end

endmodule

// File: rtl/dtm_window.sv
module dtm_window #(
    parameter int WIN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIN_W-1:0] win_len,
    input  logic             hit,
    output logic             seen_inc,
    output logic             err_inc
);
    logic [WIN_W-1:0] win_q;
    logic             open;

    assign open     = (win_q != '0);
    assign seen_inc = hit && open;
    assign err_inc  = hit && !open;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
        end else if (load) begin
            win_q <= win_len;
        end else if (hit) begin
            win_q <= '0;
        end else if (open) begin
            win_q <= win_q - WIN_W'(1);
        end
    end

endmodule

// File: rtl/dtm_scaler.sv
module dtm_scaler #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             latch,
    input  logic             inc,
    output logic [CNT_W-1:0] live,
    output logic [CNT_W-1:0] shadow
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            live <= '0;
        end else if (inc && live != CNT_MAX) begin
            live <= live + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
        end else if (latch) begin
            shadow <= live;
        end
    end

endmodule

// File: rtl/dtm_monitor.sv
module dtm_monitor
    import dtm_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int PERIOD_W = 24,
    parameter int WIN_W    = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_enable,
    input  logic                cfg_random,
    input  logic [PERIOD_W-1:0] cfg_period,
    input  logic [WIN_W-1:0]    cfg_window,
    input  logic                phys_trig,
    input  logic                acc_strobe,
    input  logic                acc_synth,
    input  logic                latch_cmd,
    input  logic                clear_cmd,
    input  logic [1:0]          rd_sel,
    output logic [CNT_W-1:0]    rd_data,
    output logic                inject_out
);
    logic                             fire;
    logic                             seen_inc;
    logic                             err_inc;
    ctr_inc_t                         inc;
    logic [NUM_CTR-1:0]               inc_vec;
    logic [NUM_CTR-1:0][CNT_W-1:0]    live_q;
    logic [NUM_CTR-1:0][CNT_W-1:0]    shadow_q;

    dtm_pulser #(.PERIOD_W(PERIOD_W)) u_pulser (
        .clk         (clk),
        .rst         (rst),
        .enable      (cfg_enable),
        .random_mode (cfg_random),
        .period      (cfg_period),
        .fire        (fire),
        .inject      (inject_out)
    );

    dtm_window #(.WIN_W(WIN_W)) u_window (
        .clk      (clk),
        .rst      (rst),
        .load     (fire),
        .win_len  (cfg_window),
        .hit      (acc_strobe && acc_synth),
        .seen_inc (seen_inc),
        .err_inc  (err_inc)
    );

    always_comb begin
        inc.sent = fire;
        inc.seen = seen_inc;
        inc.trig = phys_trig;
        inc.err  = err_inc;
        inc_vec  = inc;
    end

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        dtm_scaler #(.CNT_W(CNT_W)) u_ctr (
            .clk    (clk),
            .rst    (rst),
            .clear  (clear_cmd),
            .latch  (latch_cmd),
            .inc    (inc_vec[g]),
            .live   (live_q[g]),
            .shadow (shadow_q[g])
        );
    end

    assign rd_data = shadow_q[rd_sel];

endmodule

// File: rtl/dtm_monitor_chk.sv
module dtm_monitor_chk
    import dtm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          cfg_enable,
    input logic                          clear_cmd,
    input logic                          latch_cmd,
    input logic                          inject_out,
    input logic [NUM_CTR-1:0][CNT_W-1:0] live,
    input logic [NUM_CTR-1:0][CNT_W-1:0] shadow
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // R3
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(cfg_enable) |-> !inject_out);

    // R5
    sent_track_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(clear_cmd) && $past(live[0]) != CNT_MAX)
        |-> live[0] == $past(live[0]) + CNT_W'(inject_out));

    // R12
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $past(clear_cmd) |-> live == '0);

    // R11
    latch_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(latch_cmd)) |-> shadow == $past(live));

    // R11
    shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(latch_cmd)) |-> $stable(shadow));

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_mono
        // R10
        no_decrease_chk: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(clear_cmd)) |-> live[g] >= $past(live[g]));
    end

endmodule

bind dtm_monitor dtm_monitor_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_enable (cfg_enable),
    .clear_cmd  (clear_cmd),
    .latch_cmd  (latch_cmd),
    .inject_out (inject_out),
    .live       (live_q),
    .shadow     (shadow_q)
);

// File: tb/sim_dtm_monitor.sv
`timescale 1ns/1ps
module sim_dtm_monitor;
    localparam int CNT_W    = 8;
    localparam int PERIOD_W = 8;
    localparam int WIN_W    = 4;

    logic                clk = 1'b0;
    logic                rst;
    logic                cfg_enable, cfg_random;
    logic [PERIOD_W-1:0] cfg_period;
    logic [WIN_W-1:0]    cfg_window;
    logic                phys_trig, acc_strobe, acc_synth;
    logic                latch_cmd, clear_cmd;
    logic [1:0]          rd_sel;
    logic [CNT_W-1:0]    rd_data;
    logic                inject_out;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dtm_monitor #(.CNT_W(CNT_W), .PERIOD_W(PERIOD_W), .WIN_W(WIN_W)) u0 (
        .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_random(cfg_random),
        .cfg_period(cfg_period), .cfg_window(cfg_window), .phys_trig(phys_trig),
        .acc_strobe(acc_strobe), .acc_synth(acc_synth), .latch_cmd(latch_cmd),
        .clear_cmd(clear_cmd), .rd_sel(rd_sel), .rd_data(rd_data),
        .inject_out(inject_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic rd(input int sel, output int v);
        rd_sel = 2'(sel);
        #1;
        v = int'(rd_data);
    endtask

    task automatic do_latch();
        latch_cmd = 1'b1;
        tick();
        latch_cmd = 1'b0;
    endtask

    task automatic do_clear();
        clear_cmd = 1'b1;
        tick();
        clear_cmd = 1'b0;
    endtask

    task automatic wait_pulse();
        tick();
        while (!inject_out) tick();
    endtask

    task automatic report(input logic strobe, input logic synth);
        acc_strobe = strobe;
        acc_synth  = synth;
        tick();
        acc_strobe = 1'b0;
        acc_synth  = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v;
        int exp_seen;
        int exp_err;
        int trig_exp;
        int periods[6] = '{0, 1, 2, 3, 5, 7};

        rst = 1'b1; cfg_enable = 1'b0; cfg_random = 1'b0; cfg_period = '0;
        cfg_window = '0; phys_trig = 1'b0; acc_strobe = 1'b0; acc_synth = 1'b0;
        latch_cmd = 1'b0; clear_cmd = 1'b0; rd_sel = '0;
        repeat (4) tick();
        rst = 1'b0;
        tick();

        // R1 reset state
        chk("R1 inject", int'(inject_out), 0);
        for (int s = 0; s < 4; s++) begin
            rd(s, v);
            chk("R1 counter", v, 0);
        end

        // R2 R3 R5 fixed spacing sweep
        foreach (periods[k]) begin
            int p_exp;
            int pulses;
            int last;
            int bad;
            int quiet;
            p_exp = (periods[k] == 0) ? 1 : periods[k];
            cfg_period = PERIOD_W'(periods[k]);
            tick();
            do_clear();
            cfg_enable = 1'b1;
            pulses = 0; last = -1; bad = 0;
            for (int c = 0; c < 60; c++) begin
                tick();
                if (inject_out) begin
                    pulses++;
                    if (last >= 0 && (c - last) != p_exp) bad++;
                    last = c;
                end
            end
            chk("R2 spacing mismatches", bad, 0);
            chk("R2 pulse count", pulses, 60 / p_exp);
            cfg_enable = 1'b0;
            quiet = 0;
            for (int c = 0; c < 10; c++) begin
                tick();
                if (inject_out && c > 0) quiet++;
            end
            chk("R3 pulses while disabled", quiet, 0);
            do_latch();
            rd(0, v);
            chk("R5 sent count", v, pulses);
        end

        // R4 random spacing
        begin
            int pulses;
            int last;
            int bad;
            int mn;
            int mx;
            cfg_period = 8'd7;
            cfg_random = 1'b1;
            tick();
            do_clear();
            cfg_enable = 1'b1;
            pulses = 0; last = -1; bad = 0; mn = 1000; mx = 0;
            for (int c = 0; c < 200; c++) begin
                tick();
                if (inject_out) begin
                    pulses++;
                    if (last >= 0) begin
                        if ((c - last) < 1 || (c - last) > 8) bad++;
                        if ((c - last) < mn) mn = c - last;
                        if ((c - last) > mx) mx = c - last;
                    end
                    last = c;
                end
            end
            cfg_enable = 1'b0;
            cfg_random = 1'b0;
            chk("R4 spacing out of range", bad, 0);
            chk("R4 spacing varies", int'(mn != mx), 1);
            tick(); tick();
            do_latch();
            rd(0, v);
            chk("R5 sent count random", v, pulses);
        end

        // R6 R7 R8 window behaviour
        cfg_period = 8'd20;
        cfg_window = 4'd4;
        tick();
        do_clear();
        cfg_enable = 1'b1;
        exp_seen = 0; exp_err = 0;
        for (int d = 0; d < 7; d++) begin
            wait_pulse();
            repeat (d) tick();
            report(1'b1, 1'b1);
            if (d < 4) exp_seen++; else exp_err++;
        end
        do_latch();
        rd(1, v); chk("R6 seen after delay sweep", v, exp_seen);
        rd(3, v); chk("R7 error after delay sweep", v, exp_err);

        wait_pulse();
        report(1'b1, 1'b1);
        report(1'b1, 1'b1);
        exp_seen++; exp_err++;
        do_latch();
        rd(1, v); chk("R7 duplicate seen", v, exp_seen);
        rd(3, v); chk("R7 duplicate error", v, exp_err);

        wait_pulse();
        report(1'b1, 1'b0);
        report(1'b0, 1'b1);
        report(1'b1, 1'b1);
        exp_seen++;
        do_latch();
        rd(1, v); chk("R8 half reports ignored seen", v, exp_seen);
        rd(3, v); chk("R8 half reports ignored error", v, exp_err);

        cfg_window = '0;
        wait_pulse();
        report(1'b1, 1'b1);
        exp_err++;
        cfg_enable = 1'b0;
        repeat (25) tick();
        report(1'b1, 1'b1);
        exp_err++;
        do_latch();
        rd(1, v); chk("R6 zero window seen", v, exp_seen);
        rd(3, v); chk("R7 zero window and stray error", v, exp_err);

        // R9 trigger scaler with a sparse pattern
        do_clear();
        trig_exp = 0;
        for (int c = 0; c < 50; c++) begin
            phys_trig = (c % 3 != 0);
            if (c % 3 != 0) trig_exp++;
            tick();
        end
        phys_trig = 1'b0;
        do_latch();
        rd(2, v); chk("R9 trigger count", v, trig_exp);
        rd(0, v); chk("R12 sent cleared", v, 0);

        // R11 R12 latch coherence and clear priority
        do_clear();
        phys_trig = 1'b1;
        repeat (10) tick();
        phys_trig = 1'b0;
        do_latch();
        rd(2, v); chk("R11 latched value", v, 10);
        phys_trig = 1'b1;
        repeat (5) tick();
        phys_trig = 1'b0;
        tick();
        rd(2, v); chk("R11 shadow holds", v, 10);
        do_latch();
        rd(2, v); chk("R11 relatch", v, 15);
        phys_trig = 1'b1; latch_cmd = 1'b1; clear_cmd = 1'b1;
        tick();
        phys_trig = 1'b0; latch_cmd = 1'b0; clear_cmd = 1'b0;
        rd(2, v); chk("R12 latch with clear", v, 15);
        do_latch();
        rd(2, v); chk("R12 clear beats increment", v, 0);

        // R10 saturation
        phys_trig = 1'b1;
        repeat (300) tick();
        phys_trig = 1'b0;
        do_latch();
        rd(2, v); chk("R10 saturated", v, 255);
        phys_trig = 1'b1;
        repeat (3) tick();
        phys_trig = 1'b0;
        do_latch();
        rd(2, v); chk("R10 no wrap", v, 255);

        // R1 reset mid-run
        rst = 1'b1;
        tick();
        rst = 1'b0;
        tick();
        rd(2, v); chk("R1 reset clears shadow", v, 0);
        chk("R1 inject after reset", int'(inject_out), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule